// File: doc/BRIEF.md
# Four-Bit Function-Select ALU Slice

This block is an arithmetic and logic slice for active-high operands. A four-bit select code and a mode bit choose among sixteen bitwise logic functions and sixteen arithmetic functions. Every arithmetic function is formed as the sum of two per-bit terms derived from the operands, plus the incoming carry. Carries inside the slice are resolved by a flat lookahead network rather than a ripple chain.

Alongside the result, the slice reports a carry out for ripple cascading, group propagate and group generate flags for an external lookahead unit, and an all-ones flag on the result. In the subtract-less-one function, the all-ones flag marks equal operands, and together with the carry out it orders the operands. A single output register stage gives the slice a clocked interface. Results appear on the clock edge that samples the inputs.

Top module: `alu_slice_reg`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low at a rising edge, every output is 0 after that edge. Otherwise, the outputs after a rising edge reflect the inputs sampled at that edge.
- R2: With `logic_mode`=1, each result bit depends only on the same-position bits of A and B. For `fn_sel` 0 to 15 (bit 3 first in the binary code), the result is: ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, all ones, A|~B, A|B, A.
- R3: With `logic_mode`=1, `carry_in` has no effect on the result, and `carry_out`, `grp_prop` and `grp_gen` are all 0.
- R4: With `logic_mode`=0 and `carry_in`=0, the result is the low four bits of a raw sum. For `fn_sel` 0 to 15, that sum is: A, A|B, A|~B, 15, A+(A&~B), (A|B)+(A&~B), A+~B, (A&~B)+15, A+(A&B), A+B, (A|~B)+(A&B), (A&B)+15, A+A, (A|B)+A, (A|~B)+A, A+15. Here ~ is a four-bit complement, so adding 15 means subtracting one.
- R5: With `logic_mode`=0 and `carry_in`=1, the result is the low four bits of the raw sum plus one.
- R6: With `fn_sel`=0110 and `carry_in`=1, the result is A minus B modulo 16. `carry_out` is 1 exactly when A>=B, meaning no borrow.
- R7: In arithmetic mode, `grp_prop` is 1 exactly when the raw sum is 15 or more, and `grp_gen` is 1 exactly when it is 16 or more. Neither depends on `carry_in`.
- R8: In arithmetic mode, `carry_out` is 1 exactly when the raw sum plus `carry_in` is 16 or more.
- R9: `all_ones` is 1 exactly when all four result bits are 1.
- R10: With `fn_sel`=0110, `carry_in`=0 and arithmetic mode, `all_ones`=1 means A=B. `carry_out`=1 means A>B. Both flags at 0 means A<B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_a | input | WIDTH (4) | Operand A |
| in_b | input | WIDTH (4) | Operand B |
| fn_sel | input | 4 | Function select code |
| logic_mode | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| carry_in | input | 1 | Active-high incoming carry |
| result | output | WIDTH (4) | Registered function result |
| carry_out | output | 1 | Registered active-high carry out |
| grp_prop | output | 1 | Registered group propagate (raw sum at least 15) |
| grp_gen | output | 1 | Registered group generate (raw sum at least 16) |
| all_ones | output | 1 | Registered flag: every result bit is 1 |

## Verification
The comparison use case depends on two functions settling in the same cycle. In the subtract-less-one function, the carry out and the all-ones flag are produced together, and their joint value must identify exactly one of A>B, A=B or A<B. The sweep covers all 256 operand pairs of that code, and each pair is judged against an ordering computed directly from the integers. In the same way, the group flags and the carry out share every arithmetic cycle. Flipping `carry_in` while holding the operands must move the carry and the result, and must leave propagate and generate unchanged.

// File: rtl/alu_slice_pkg.sv
// Package: shared definitions for the ALU slice.
// Assumes a four-bit select code whose bits gate fixed operand terms.
package alu_slice_pkg;
    localparam int SEL_W      = 4;
    // Select bit roles when forming the two addend terms
    localparam int SEL_B_OR   = 0;  // OR B into the X term
    localparam int SEL_NB_OR  = 1;  // OR ~B into the X term
    localparam int SEL_NB_AND = 2;  // A&~B into the Y term
    localparam int SEL_B_AND  = 3;  // A&B into the Y term

    typedef struct packed {
        logic cout;
        logic prop;
        logic gen;
        logic eq;
    } slice_flags_t;
endpackage

// File: rtl/alu_term_former.sv
// Module: forms the per-bit addend terms X and Y from A, B and the select code.
// Assumes: every function is X+Y (+carry) in arithmetic mode and ~(X^Y) in logic mode.
module alu_term_former
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [SEL_W-1:0] sel,
    output logic [WIDTH-1:0] x_term,
    output logic [WIDTH-1:0] y_term
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Purpose: X gathers A plus the selected B polarity
        assign x_term[i] = op_a[i] | (sel[SEL_B_OR] & op_b[i]) | (sel[SEL_NB_OR] & ~op_b[i]);
        // Purpose: Y gathers A masked by the selected B polarity
        assign y_term[i] = op_a[i] & ((sel[SEL_NB_AND] & ~op_b[i]) | (sel[SEL_B_AND] & op_b[i]));
    end
endmodule

// File: rtl/alu_lookahead.sv
// Module: flat carry lookahead over WIDTH bits.
// Assumes: propagate = x^y and generate = x&y per bit. Each carry is a flat
// sum of products with no ripple dependence between carry outputs.
module alu_lookahead #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_term,
    input  logic [WIDTH-1:0] y_term,
    input  logic             cin,
    output logic [WIDTH:0]   carry_vec,
    output logic             grp_gen,
    output logic             grp_prop
);
    logic [WIDTH-1:0] bit_p;
    logic [WIDTH-1:0] bit_g;

    assign bit_p = x_term ^ y_term;
    assign bit_g = x_term & y_term;

    // Purpose: each carry is the OR of generate terms qualified by the propagates above them
    always_comb begin
        logic run_p;
        logic acc_c;
        carry_vec[0] = cin;
        for (int i = 0; i < WIDTH; i++) begin
            run_p = 1'b1;
            acc_c = 1'b0;
            for (int j = i; j >= 0; j--) begin
                acc_c = acc_c | (run_p & bit_g[j]);
                run_p = run_p & bit_p[j];
            end
            carry_vec[i+1] = acc_c | (run_p & cin);
        end
    end

    // Purpose: group generate, independent of the incoming carry
    always_comb begin
        logic run_g;
        grp_gen = 1'b0;
        run_g   = 1'b1;
        for (int j = WIDTH - 1; j >= 0; j--) begin
            grp_gen = grp_gen | (run_g & bit_g[j]);
            run_g   = run_g & bit_p[j];
        end
    end

    // Purpose: group propagate, meaning a carry in would reach the carry out (sum >= 2^WIDTH-1)
    assign grp_prop = grp_gen | (&bit_p);
endmodule

// File: rtl/alu_result_stage.sv
// Module: combines the terms and carries into the result and flags.
// Assumes: logic mode inhibits all carries and forces the carry flags low.
module alu_result_stage
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_term,
    input  logic [WIDTH-1:0] y_term,
    input  logic [WIDTH-1:0] bit_carry,
    input  logic             grp_cout,
    input  logic             grp_gen,
    input  logic             grp_prop,
    input  logic             logic_mode,
    output logic [WIDTH-1:0] f_val,
    output slice_flags_t     flags
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_res
        // Purpose: sum bit in arithmetic mode, inverted term parity in logic mode
        assign f_val[i] = logic_mode ? ~(x_term[i] ^ y_term[i])
                                     : (x_term[i] ^ y_term[i] ^ bit_carry[i]);
    end

    // Purpose: flag assembly with carry outputs gated by the mode
    always_comb begin
        flags.cout = ~logic_mode & grp_cout;
        flags.prop = ~logic_mode & grp_prop;
        flags.gen  = ~logic_mode & grp_gen;
        flags.eq   = &f_val;
    end
endmodule

// File: rtl/alu_slice_reg.sv
// Module: top of the ALU slice. It holds the combinational core followed by one output register stage.
// Assumes: synchronous active-low reset; inputs are sampled on every rising edge.
module alu_slice_reg
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [3:0]       fn_sel,
    input  logic             logic_mode,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             grp_prop,
    output logic             grp_gen,
    output logic             all_ones
);
    logic [WIDTH-1:0] x_term;
    logic [WIDTH-1:0] y_term;
    logic [WIDTH:0]   carry_vec;
    logic             la_gen;
    logic             la_prop;
    logic [WIDTH-1:0] f_comb;
    slice_flags_t     flags_comb;
    logic [WIDTH-1:0] f_q;
    slice_flags_t     flags_q;

    alu_term_former #(.WIDTH(WIDTH)) u_terms (
        .op_a   (in_a),
        .op_b   (in_b),
        .sel    (fn_sel),
        .x_term (x_term),
        .y_term (y_term)
    );

    alu_lookahead #(.WIDTH(WIDTH)) u_cla (
        .x_term    (x_term),
        .y_term    (y_term),
        .cin       (carry_in),
        .carry_vec (carry_vec),
        .grp_gen   (la_gen),
        .grp_prop  (la_prop)
    );

    alu_result_stage #(.WIDTH(WIDTH)) u_res (
        .x_term     (x_term),
        .y_term     (y_term),
        .bit_carry  (carry_vec[WIDTH-1:0]),
        .grp_cout   (carry_vec[WIDTH]),
        .grp_gen    (la_gen),
        .grp_prop   (la_prop),
        .logic_mode (logic_mode),
        .f_val      (f_comb),
        .flags      (flags_comb)
    );

    // Purpose: output register stage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q     <= '0;
            flags_q <= '0;
        end else begin
            f_q     <= f_comb;
            flags_q <= flags_comb;
        end
    end

    assign result    = f_q;
    assign carry_out = flags_q.cout;
    assign grp_prop  = flags_q.prop;
    assign grp_gen   = flags_q.gen;
    assign all_ones  = flags_q.eq;
endmodule

// File: rtl/alu_slice_chk.sv
// Module: assertion checker for the ALU slice, attached by bind.
// Assumes: the same port names as the top module; observes only ports.
module alu_slice_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic [3:0]       fn_sel,
    input logic             logic_mode,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             grp_prop,
    input logic             grp_gen,
    input logic             all_ones
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !carry_out && !grp_prop && !grp_gen && !all_ones));

    // R3
    logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(logic_mode)) |-> (!carry_out && !grp_prop && !grp_gen));

    // R7
    gen_implies_prop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_gen |-> grp_prop);

    // R8
    gen_forces_cout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_gen |-> carry_out);

    // R8
    prop_with_cin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!logic_mode && carry_in) && grp_prop) |-> carry_out);

    // R10
    equal_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!logic_mode && !carry_in && fn_sel == 4'b0110 && in_a == in_b))
        |-> (all_ones && !carry_out));
endmodule

bind alu_slice_reg alu_slice_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_slice_reg_tb.sv
module alu_slice_reg_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_a = '1;
    logic [W-1:0] in_b = '0;
    logic [3:0]   fn_sel = 4'b1100;
    logic         logic_mode = 1'b1;
    logic         carry_in = 1'b1;
    logic [W-1:0] result;
    logic         carry_out, grp_prop, grp_gen, all_ones;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int a; int b; int s; bit m; bit c;
        int f; bit co; bit p; bit g; bit eq;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    alu_slice_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .fn_sel(fn_sel),
        .logic_mode(logic_mode), .carry_in(carry_in), .result(result),
        .carry_out(carry_out), .grp_prop(grp_prop), .grp_gen(grp_gen), .all_ones(all_ones)
    );

    // Raw arithmetic sum from the R4 table, before the carry in
    function automatic int arith_raw(int a, int b, int s);
        int nb = 15 - b;
        case (s)
            0: return a;                 1: return a | b;
            2: return a | nb;            3: return 15;
            4: return a + (a & nb);      5: return (a | b) + (a & nb);
            6: return a + nb;            7: return (a & nb) + 15;
            8: return a + (a & b);       9: return a + b;
            10: return (a | nb) + (a & b); 11: return (a & b) + 15;
            12: return a + a;            13: return (a | b) + a;
            14: return (a | nb) + a;     default: return a + 15;
        endcase
    endfunction

    // Logic function from the R2 table
    function automatic int logic_ref(int a, int b, int s);
        int na = 15 - a;
        int nb = 15 - b;
        case (s)
            0: return na;            1: return 15 - (a | b);
            2: return na & b;        3: return 0;
            4: return 15 - (a & b);  5: return nb;
            6: return a ^ b;         7: return a & nb;
            8: return na | b;        9: return 15 - (a ^ b);
            10: return b;            11: return a & b;
            12: return 15;           13: return a | nb;
            14: return a | b;        default: return a;
        endcase
    endfunction

    task automatic check_val(string tag, int got, int exp, exp_t it);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: a=%0d b=%0d sel=%0d mode=%0d cin=%0d got=%0d exp=%0d",
                     tag, it.a, it.b, it.s, it.m, it.c, got, exp);
        end
    endtask

    // Driver: apply one stimulus on the falling edge and queue its expectation
    task automatic drive_item(int a, int b, int s, bit m, bit c);
        exp_t it;
        int raw;
        @(negedge clk);
        in_a = W'(a); in_b = W'(b); fn_sel = 4'(s); logic_mode = m; carry_in = c;
        it.a = a; it.b = b; it.s = s; it.m = m; it.c = c;
        if (m) begin
            it.f = logic_ref(a, b, s);
            it.co = 0; it.p = 0; it.g = 0;
        end else begin
            raw = arith_raw(a, b, s);
            it.f = (raw + int'(c)) % 16;
            it.co = (raw + int'(c)) >= 16;
            it.p = raw >= 15;
            it.g = raw >= 16;
        end
        it.eq = (it.f == 15);
        sb_q.push_back(it);
    endtask

    // Monitor: results appear after the rising edge that samples the inputs (R1)
    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            if (it.m) begin
                check_val("R2", int'(result), it.f, it);
                check_val("R3", {carry_out, grp_prop, grp_gen}, 0, it);
            end else begin
                check_val(it.c ? "R5" : "R4", int'(result), it.f, it);
                check_val("R7", {grp_prop, grp_gen}, {it.p, it.g}, it);
                check_val("R8", int'(carry_out), int'(it.co), it);
                if (it.s == 6 && it.c) begin
                    check_val("R6", int'(result), (it.a - it.b + 16) % 16, it);
                    check_val("R6", int'(carry_out), int'(it.a >= it.b), it);
                end
                if (it.s == 6 && !it.c) begin
                    check_val("R10", {all_ones, carry_out},
                              (it.a == it.b) ? 2 : ((it.a > it.b) ? 1 : 0), it);
                end
            end
            check_val("R9", int'(all_ones), int'(it.eq), it);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(20 * 60000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got=timeout exp=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t rst_it;
        rst_it = '{default: 0};
        // R1: inputs would give all ones, but reset holds the outputs at zero
        repeat (3) @(posedge clk);
        #5;
        check_val("R1", {result, carry_out, grp_prop, grp_gen, all_ones}, 0, rst_it);
        @(negedge clk);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 16; s++)
                for (int c = 0; c < 2; c++)
                    for (int a = 0; a < 16; a++)
                        for (int b = 0; b < 16; b++)
                            drive_item(a, b, s, bit'(m), bit'(c));
        // R7: same operands, carry in toggled, group flags stay put
        drive_item(7, 8, 9, 1'b0, 1'b0);
        drive_item(7, 8, 9, 1'b0, 1'b1);
        drive_item(15, 1, 9, 1'b0, 1'b1);
        wait (sb_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule